// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block is a data cache for a 16-bit byte address space. It keeps 128 frames of 16 bytes (four 32-bit words), organised as 64 sets of two ways. A processor-side request carries a byte address, a write flag and a write word. The set index picks one set, and both stored tags in that set are compared with the address tag at the same time. On a hit the selected word is returned, or the write is merged into it, in the same cycle. Writes never go to memory directly. Instead, each frame has a dirty flag that marks it for write-back when the frame is later replaced.

On a miss a small sequencer takes over and holds the processor stalled. If the chosen victim frame is dirty, it first writes the whole victim block to memory. It then fetches the requested block into that frame. It finishes with a single response cycle that serves the original read or write from the freshly filled frame. Write misses allocate: the block is fetched, then the word is merged and the frame is marked dirty.

The victim is an empty way whenever the set has one. When both ways are occupied, a mode input selects between a one-bit-per-set least-recently-used record and a free-running pseudo-random bit.

The processor must hold `cpu_req`, `cpu_we`, `cpu_addr` and `cpu_wdata` steady until it sees `cpu_ready`. The memory side must hold `mem_rdata` valid in the cycle it pulses `mem_ack` for a fill.

The sequencer states and their transitions are:
- IDLE: performs the lookup. A missing request goes to WRITEBACK when the victim is valid and dirty, and to FILL otherwise.
- WRITEBACK: goes to FILL on `mem_ack`.
- FILL: goes to RESPOND on `mem_ack`.
- RESPOND: always returns to IDLE after one cycle.

Top module: `assoc_wb_cache`

## Requirements
- R1: The address splits into tag = bits 15:10, set index = bits 9:4 and block offset = bits 3:0. Bits 3:2 select the word in the block; word k lies in bits 32k+31:32k of the 128-bit block. Bits 1:0 are ignored.
- R2: A request whose tag matches a valid way of its set raises `cpu_ready` and `cpu_hit` in the same cycle. On a read, `cpu_rdata` carries the addressed word. No memory request is made.
- R3: A write hit updates only the cached word and marks that frame dirty. It causes no memory traffic, and a later read returns the new word.
- R4: A read miss holds `cpu_ready` low and requests the block-aligned address with `mem_we` = 0. The cycle after the fill `mem_ack`, the block responds with `cpu_ready` = 1, `cpu_hit` = 0 and the addressed word of the fetched block.
- R5: A write miss allocates. The block is fetched, the written word is merged into it in the response cycle, the frame becomes dirty, and the other words keep the fetched values.
- R6: A valid dirty victim is written back (`mem_we` = 1, address = victim tag with the current index and zero offset, data = the whole victim block) before the fill. A clean victim is dropped with no memory write.
- R7: An invalid way is always taken as the victim: way 0 if it is invalid, otherwise way 1 if it is invalid. The replacement mode matters only when both ways are valid.
- R8: With `repl_lru` = 1, the victim is the way of the set not touched by the most recent access. Every hit and every response cycle counts as a touch.
- R9: With `repl_lru` = 0, the victim of a full set comes from a free-running pseudo-random bit. Exactly one of the two resident blocks is evicted and the other stays resident.
- R10: Reset clears every valid, dirty and LRU bit. After reset no request hits and no write-back occurs.
- R11: The sequencer follows IDLE → WRITEBACK → FILL → RESPOND → IDLE, or IDLE → FILL → RESPOND → IDLE when no write-back is needed. `cpu_ready` stays low while a memory request is open, and a write-back acknowledge is followed at once by the fill request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| repl_lru | input | 1 | 1 selects LRU victims, 0 selects pseudo-random victims |
| cpu_req | input | 1 | Processor request valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 16 | Byte address of the request |
| cpu_wdata | input | 32 | Word to write |
| cpu_rdata | output | 32 | Word read, valid with `cpu_ready` |
| cpu_ready | output | 1 | Request served in this cycle |
| cpu_hit | output | 1 | Request served by a hit without a memory access |
| mem_req | output | 1 | Memory request open, held until `mem_ack` |
| mem_we | output | 1 | 1 for a write-back, 0 for a fill |
| mem_addr | output | 16 | Block-aligned memory address |
| mem_wdata | output | 128 | Block being written back |
| mem_rdata | input | 128 | Block returned by a fill |
| mem_ack | input | 1 | One-cycle acknowledge of the open memory request |

## Verification
The bound checker watches the protocol on every cycle:
- `cpu_ready` stays low while a memory request is open, and a hit never comes without ready.
- Fill addresses are the block-aligned request address.
- A write-back address carries the current index and a tag different from the request.
- A write-back acknowledge is followed by a fill request, and a fill acknowledge by a miss response.

Only the directed scenarios can show the data-dependent behaviour: which way becomes the victim under LRU, random and invalid-first choice; that dirty bits turn into write-backs carrying the written word while clean victims do not; and that reset discards stored blocks.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WRITEBACK = 2'd1,
        ST_FILL      = 2'd2,
        ST_RESPOND   = 2'd3
    } miss_state_e;

endpackage

// File: rtl/wbc_way.sv
module wbc_way #(
    parameter int TAG_W  = 6,
    parameter int IDX_W  = 6,
    parameter int WORDS  = 4,
    parameter int WORD_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [IDX_W-1:0]           idx,
    input  logic                       fill_en,
    input  logic [TAG_W-1:0]           fill_tag,
    input  logic [WORDS*WORD_W-1:0]    fill_line,
    input  logic                       word_we,
    input  logic [$clog2(WORDS)-1:0]   word_sel,
    input  logic [WORD_W-1:0]          word_data,
    output logic [TAG_W-1:0]           rd_tag,
    output logic                       rd_valid,
    output logic                       rd_dirty,
    output logic [WORDS*WORD_W-1:0]    rd_line
);

    localparam int SETS   = 1 << IDX_W;
    localparam int LINE_W = WORDS * WORD_W;

    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] line_q [SETS];
    logic [SETS-1:0]   valid_q;
    logic [SETS-1:0]   dirty_q;

    // status bits: cleared by reset, set by fill or write
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (word_we) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    // tag and block storage, no reset needed
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[idx]  <= fill_tag;
            line_q[idx] <= fill_line;
        end else if (word_we) begin
            line_q[idx][int'(word_sel)*WORD_W +: WORD_W] <= word_data;
        end
    end

    always_comb begin
        rd_tag   = tag_q[idx];
        rd_line  = line_q[idx];
        rd_valid = valid_q[idx];
        rd_dirty = dirty_q[idx];
    end

endmodule

// File: rtl/wbc_victim_sel.sv
module wbc_victim_sel #(
    parameter int                IDX_W     = 6,
    parameter int                LFSR_W    = 8,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8,
    parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h01
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       way_valid,
    input  logic             lru_mode,
    input  logic             touch_en,
    input  logic             touch_way,
    output logic             victim
);

    localparam int SETS = 1 << IDX_W;

    // one bit per set: the way not most recently touched
    logic [SETS-1:0]   lru_q;
    logic [LFSR_W-1:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_q  <= '0;
            lfsr_q <= LFSR_SEED;
        end else begin
            lfsr_q <= (lfsr_q >> 1) ^ (lfsr_q[0] ? LFSR_TAPS : '0);
            if (touch_en) begin
                lru_q[idx] <= ~touch_way;
            end
        end
    end

    always_comb begin
        if (!way_valid[0]) begin
            victim = 1'b0;
        end else if (!way_valid[1]) begin
            victim = 1'b1;
        end else if (lru_mode) begin
            victim = lru_q[idx];
        end else begin
            victim = lfsr_q[0];
        end
    end

endmodule

// File: rtl/wbc_miss_fsm.sv
module wbc_miss_fsm
    import wbc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        hit_any,
    input  logic        need_wb,
    input  logic        mem_ack,
    output miss_state_e state,
    output logic        cpu_ready,
    output logic        cpu_hit,
    output logic        mem_req,
    output logic        mem_we,
    output logic        latch_victim
);

    miss_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req && !hit_any) begin
                    state_d = need_wb ? ST_WRITEBACK : ST_FILL;
                end
            end
            ST_WRITEBACK: if (mem_ack) state_d = ST_FILL;
            ST_FILL:      if (mem_ack) state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_ready    = 1'b0;
        cpu_hit      = 1'b0;
        mem_req      = 1'b0;
        mem_we       = 1'b0;
        latch_victim = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cpu_ready    = cpu_req && hit_any;
                cpu_hit      = cpu_req && hit_any;
                latch_victim = cpu_req && !hit_any;
            end
            ST_WRITEBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_FILL: begin
                mem_req = 1'b1;
            end
            ST_RESPOND: begin
                cpu_ready = 1'b1;
            end
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/assoc_wb_cache.sv
module assoc_wb_cache
    import wbc_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                IDX_W     = 6,
    parameter int                WORDS     = 4,
    parameter int                WORD_W    = 32,
    parameter int                LFSR_W    = 8,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'hB8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     repl_lru,
    input  logic                     cpu_req,
    input  logic                     cpu_we,
    input  logic [ADDR_W-1:0]        cpu_addr,
    input  logic [WORD_W-1:0]        cpu_wdata,
    output logic [WORD_W-1:0]        cpu_rdata,
    output logic                     cpu_ready,
    output logic                     cpu_hit,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [WORDS*WORD_W-1:0]  mem_wdata,
    input  logic [WORDS*WORD_W-1:0]  mem_rdata,
    input  logic                     mem_ack
);

    localparam int LINE_W = WORDS * WORD_W;
    localparam int BSEL_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int OFF_W  = BSEL_W + WSEL_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    // address fields
    logic [TAG_W-1:0]  addr_tag;
    logic [IDX_W-1:0]  addr_idx;
    logic [WSEL_W-1:0] addr_wsel;
    logic              unused_byte_bits;

    assign addr_tag         = cpu_addr[ADDR_W-1 -: TAG_W];
    assign addr_idx         = cpu_addr[OFF_W +: IDX_W];
    assign addr_wsel        = cpu_addr[BSEL_W +: WSEL_W];
    assign unused_byte_bits = ^cpu_addr[BSEL_W-1:0];

    // per-way read ports
    logic [TAG_W-1:0]  way_tag  [WAYS];
    logic [LINE_W-1:0] way_line [WAYS];
    logic [WAYS-1:0]   way_valid;
    logic [WAYS-1:0]   way_dirty;
    logic [WAYS-1:0]   match;
    logic [WAYS-1:0]   fill_en;
    logic [WAYS-1:0]   word_we;

    miss_state_e state;
    logic        hit_any;
    logic        hit_way;
    logic        victim_now;
    logic        vic_q;
    logic        need_wb;
    logic        latch_victim;
    logic        access;
    logic        fill_done;

    assign access    = cpu_req && cpu_ready;
    assign fill_done = (state == ST_FILL) && mem_ack;

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_way
            wbc_way #(
                .TAG_W  (TAG_W),
                .IDX_W  (IDX_W),
                .WORDS  (WORDS),
                .WORD_W (WORD_W)
            ) way_i (
                .clk       (clk),
                .rst       (rst),
                .idx       (addr_idx),
                .fill_en   (fill_en[g]),
                .fill_tag  (addr_tag),
                .fill_line (mem_rdata),
                .word_we   (word_we[g]),
                .word_sel  (addr_wsel),
                .word_data (cpu_wdata),
                .rd_tag    (way_tag[g]),
                .rd_valid  (way_valid[g]),
                .rd_dirty  (way_dirty[g]),
                .rd_line   (way_line[g])
            );

            // parallel compare, gated by valid
            assign match[g]   = way_valid[g] && (way_tag[g] == addr_tag);
            assign fill_en[g] = fill_done && (vic_q == 1'(g));
            assign word_we[g] = access && cpu_we && match[g];
        end
    endgenerate

    assign hit_any = |match;
    assign hit_way = match[1];

    wbc_victim_sel #(
        .IDX_W     (IDX_W),
        .LFSR_W    (LFSR_W),
        .LFSR_TAPS (LFSR_TAPS)
    ) victim_i (
        .clk       (clk),
        .rst       (rst),
        .idx       (addr_idx),
        .way_valid (way_valid),
        .lru_mode  (repl_lru),
        .touch_en  (access),
        .touch_way (hit_way),
        .victim    (victim_now)
    );

    assign need_wb = way_valid[victim_now] && way_dirty[victim_now];

    // victim way is frozen when the miss is detected
    always_ff @(posedge clk) begin
        if (rst) begin
            vic_q <= 1'b0;
        end else if (latch_victim) begin
            vic_q <= victim_now;
        end
    end

    wbc_miss_fsm fsm_i (
        .clk          (clk),
        .rst          (rst),
        .cpu_req      (cpu_req),
        .hit_any      (hit_any),
        .need_wb      (need_wb),
        .mem_ack      (mem_ack),
        .state        (state),
        .cpu_ready    (cpu_ready),
        .cpu_hit      (cpu_hit),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .latch_victim (latch_victim)
    );

    // data out: way mux steered by compare, then word select
    assign cpu_rdata = way_line[hit_way][int'(addr_wsel)*WORD_W +: WORD_W];

    // memory side
    always_comb begin
        if (state == ST_WRITEBACK) begin
            mem_addr = {way_tag[vic_q], addr_idx, {OFF_W{1'b0}}};
        end else begin
            mem_addr = {addr_tag, addr_idx, {OFF_W{1'b0}}};
        end
    end

    assign mem_wdata = way_line[vic_q];

endmodule

// File: rtl/wbc_checker.sv
module wbc_checker #(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 6,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_ready,
    input logic              cpu_hit,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack
);

    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    // R11: processor is stalled while memory is busy
    p_stall_while_mem_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cpu_ready);

    // R2: a hit is always a served request
    p_hit_has_ready_r2: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |-> (cpu_ready && cpu_req));

    // R4: fill address is the block-aligned request address
    p_fill_addr_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |->
            (mem_addr == {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}));

    // R6: write-back targets another tag of the same set
    p_wb_addr_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |->
            ((mem_addr[ADDR_W-1 -: TAG_W] != cpu_addr[ADDR_W-1 -: TAG_W]) &&
             (mem_addr[OFF_W +: IDX_W] == cpu_addr[OFF_W +: IDX_W]) &&
             (mem_addr[OFF_W-1:0] == '0)));

    // R11: write-back acknowledge leads straight to the fill
    p_wb_then_fill_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we));

    // R4: fill acknowledge leads to the miss response
    p_fill_then_respond_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack) |=> (cpu_ready && !cpu_hit));

    // R10: nothing is resident or pending right after reset
    p_reset_empty_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!mem_req && !cpu_hit));

endmodule

bind assoc_wb_cache wbc_checker #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_addr  (cpu_addr),
    .cpu_ready (cpu_ready),
    .cpu_hit   (cpu_hit),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack)
);

// File: tb/assoc_wb_cache_tb_top.sv
module assoc_wb_cache_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         repl_lru = 1'b1;
    logic         cpu_req = 1'b0;
    logic         cpu_we = 1'b0;
    logic [15:0]  cpu_addr = '0;
    logic [31:0]  cpu_wdata = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ready;
    logic         cpu_hit;
    logic         mem_req;
    logic         mem_we;
    logic [15:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_ack = 1'b0;

    always #5 clk = ~clk;

    assoc_wb_cache dut_i (
        .clk       (clk),
        .rst       (rst),
        .repl_lru  (repl_lru),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .cpu_ready (cpu_ready),
        .cpu_hit   (cpu_hit),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // backing memory and reference of processor-visible words
    logic [127:0] bmem    [logic [11:0]];
    logic [31:0]  ref_wrd [logic [13:0]];

    int          wb_cnt = 0, fill_cnt = 0, ev_seq = 0, wb_seq = 0, fill_seq = 0;
    logic [15:0] last_wb_addr = '0, last_fill_addr = '0;
    logic [127:0] last_wb_data = '0;

    function automatic logic [31:0] pat(input logic [11:0] blk, input logic [1:0] w);
        return {4'hB, blk, 6'h00, w, 8'h5A};
    endfunction

    function automatic logic [127:0] blk_line(input logic [11:0] blk);
        if (bmem.exists(blk)) return bmem[blk];
        return {pat(blk, 2'd3), pat(blk, 2'd2), pat(blk, 2'd1), pat(blk, 2'd0)};
    endfunction

    function automatic logic [31:0] exp_word(input logic [15:0] a);
        if (ref_wrd.exists(a[15:2])) return ref_wrd[a[15:2]];
        return pat(a[15:4], a[3:2]);
    endfunction

    function automatic logic [15:0] mk(input int tag, input int idx, input int w);
        return {tag[5:0], idx[5:0], w[1:0], 2'b00};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory responder: two-cycle latency, one-cycle ack
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !rst) begin
                repeat (2) @(negedge clk);
                ev_seq++;
                if (mem_we) begin
                    bmem[mem_addr[15:4]] = mem_wdata;
                    last_wb_addr = mem_addr;
                    last_wb_data = mem_wdata;
                    wb_cnt++;
                    wb_seq = ev_seq;
                end else begin
                    mem_rdata = blk_line(mem_addr[15:4]);
                    last_fill_addr = mem_addr;
                    fill_cnt++;
                    fill_seq = ev_seq;
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    task automatic access(input logic we, input logic [15:0] a, input logic [31:0] wd,
                          output logic [31:0] rd, output logic hit);
        int cyc = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        while (!cpu_ready && cyc < 200) begin
            @(negedge clk); #1; cyc++;
        end
        if (!cpu_ready) check("R11", "request never served", 0, 1);
        rd  = cpu_rdata;
        hit = cpu_hit;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        if (we) ref_wrd[a[15:2]] = wd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_and_read();
        logic [31:0] rd; logic hit; int f0;
        #1;
        check("R10", "ready after reset", cpu_ready, 0);
        check("R10", "mem_req after reset", mem_req, 0);
        f0 = fill_cnt;
        access(0, mk(1, 0, 2), 0, rd, hit);
        check("R4", "first read hit flag", hit, 0);
        check("R4", "fill count", fill_cnt, f0 + 1);
        check("R4", "fill address aligned", last_fill_addr, mk(1, 0, 0));
        check("R1", "miss word 2 data", rd, exp_word(mk(1, 0, 2)));
        access(0, mk(1, 0, 3) | 16'h3, 0, rd, hit);
        check("R2", "read hit flag", hit, 1);
        check("R1", "hit word 3 data, byte bits ignored", rd, exp_word(mk(1, 0, 3)));
        check("R2", "no fill on hit", fill_cnt, f0 + 1);
    endtask

    task automatic t_write_hit();
        logic [31:0] rd; logic hit; int f0, w0;
        f0 = fill_cnt; w0 = wb_cnt;
        access(1, mk(1, 0, 1), 32'hDEAD_0001, rd, hit);
        check("R3", "write hit flag", hit, 1);
        check("R3", "no memory traffic", fill_cnt + wb_cnt, f0 + w0);
        access(0, mk(1, 0, 1), 0, rd, hit);
        check("R3", "read back written word", rd, 32'hDEAD_0001);
        check("R3", "read back is hit", hit, 1);
    endtask

    task automatic t_write_miss();
        logic [31:0] rd; logic hit; int f0, w0;
        f0 = fill_cnt; w0 = wb_cnt;
        access(1, mk(2, 1, 2), 32'hFACE_0002, rd, hit);
        check("R5", "write miss flag", hit, 0);
        check("R5", "block fetched", fill_cnt, f0 + 1);
        check("R5", "no write-back", wb_cnt, w0);
        access(0, mk(2, 1, 2), 0, rd, hit);
        check("R5", "merged word", rd, 32'hFACE_0002);
        check("R5", "merged word hits", hit, 1);
        access(0, mk(2, 1, 0), 0, rd, hit);
        check("R5", "other word from memory", rd, pat(mk(2, 1, 0) >> 4, 2'd0));
    endtask

    task automatic t_invalid_first();
        logic [31:0] rd; logic hit; int f0, w0;
        access(0, mk(3, 2, 0), 0, rd, hit);
        access(0, mk(4, 2, 0), 0, rd, hit);
        f0 = fill_cnt; w0 = wb_cnt;
        access(0, mk(3, 2, 1), 0, rd, hit);
        check("R7", "first block kept", hit, 1);
        access(0, mk(4, 2, 1), 0, rd, hit);
        check("R7", "second block in empty way", hit, 1);
        check("R7", "no extra memory traffic", fill_cnt + wb_cnt, f0 + w0);
    endtask

    task automatic t_lru_dirty();
        logic [31:0] rd; logic hit; int w0;
        repl_lru = 1'b1;
        access(1, mk(5, 3, 0), 32'h1111_0005, rd, hit);
        access(1, mk(6, 3, 1), 32'h2222_0006, rd, hit);
        access(0, mk(5, 3, 0), 0, rd, hit);
        w0 = wb_cnt;
        access(0, mk(7, 3, 0), 0, rd, hit);
        check("R8", "LRU way written back", wb_cnt, w0 + 1);
        check("R8", "victim is least recent block", last_wb_addr, mk(6, 3, 0));
        check("R6", "write-back carries dirty word", last_wb_data[63:32], 32'h2222_0006);
        check("R11", "write-back before fill", (wb_seq < fill_seq), 1);
        access(0, mk(5, 3, 0), 0, rd, hit);
        check("R8", "recent block survives", hit, 1);
        check("R8", "recent block data", rd, 32'h1111_0005);
        w0 = wb_cnt;
        access(0, mk(6, 3, 1), 0, rd, hit);
        check("R6", "clean victim dropped", wb_cnt, w0);
        check("R6", "evicted data returns from memory", rd, 32'h2222_0006);
    endtask

    task automatic t_random();
        logic [31:0] rd; logic hit; int w0, gone, kept;
        repl_lru = 1'b0;
        access(1, mk(8, 4, 0), 32'h3333_0008, rd, hit);
        access(1, mk(9, 4, 0), 32'h4444_0009, rd, hit);
        w0 = wb_cnt;
        access(0, mk(10, 4, 0), 0, rd, hit);
        check("R9", "one dirty block evicted", wb_cnt, w0 + 1);
        gone = int'(last_wb_addr[15:10]);
        check("R9", "evicted tag is a resident", (gone == 8 || gone == 9), 1);
        kept = (gone == 8) ? 9 : 8;
        access(0, mk(kept, 4, 0), 0, rd, hit);
        check("R9", "other block stays resident", hit, 1);
        access(0, mk(gone, 4, 0), 0, rd, hit);
        check("R9", "evicted block misses", hit, 0);
        check("R9", "evicted block data", rd, exp_word(mk(gone, 4, 0)));
        repl_lru = 1'b1;
    endtask

    task automatic t_reset_clears();
        logic [31:0] rd; logic hit; int w0;
        access(1, mk(11, 5, 0), 32'h5555_000B, rd, hit);
        do_reset();
        w0 = wb_cnt;
        access(0, mk(11, 5, 0), 0, rd, hit);
        check("R10", "dirty block gone after reset", hit, 0);
        check("R10", "no write-back after reset", wb_cnt, w0);
        access(0, mk(1, 0, 3), 0, rd, hit);
        check("R10", "old block misses after reset", hit, 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_and_read();
        t_write_hit();
        t_write_miss();
        t_invalid_first();
        t_lru_dirty();
        t_random();
        t_reset_clears();
        done = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            finish_run();
        end
    end

endmodule